// File: doc/BRIEF.md
# Vectored Byte I/O Port

This block is a byte-wide peripheral controller that a processor reaches through memory addresses. Four registers sit in an eight-byte window that starts at a parameterised base address. The four registers are received data, transmit data, a status and enable word, and an interrupt vector number. The peripheral side has two parts. Received bytes arrive as single-cycle strobes. Transmit bytes leave through a valid/ready handshake.

Software has two ways to service the port. It can poll the status word, or it can set the per-direction enable bits and let the block raise an interrupt request. The processor answers the request with an acknowledge. If this port is requesting, it places its programmed vector number on the read data bus. If it is not requesting, it passes the acknowledge on to the next device in the chain, so that the first requester in the chain wins.

Top module: `vio_port`

## Requirements
- R1: After reset the status word reads 0x02, meaning the transmitter is free and no data or overrun is pending. The vector register reads 15, `irq` is low and `tx_valid` is low.
- R2: A received strobe stores `rx_data` and sets status bit 0. A read of offset 0 returns the byte and clears bit 0.
- R3: A write to offset 2 loads the transmit byte, clears status bit 1 and raises `tx_valid` with that byte. The byte stays stable until `tx_ready` is seen. The handshake then drops `tx_valid` and sets bit 1 again.
- R4: Status bit 2 (receive interrupt enable) and bit 3 (transmit interrupt enable) are written at offset 4 and read back there. Bits 4 to 6 always read as zero, and writes to them have no effect.
- R5: `irq` is high exactly when (bit 0 and bit 2) or (bit 1 and bit 3) holds. The request clears once the pending condition has been serviced.
- R6: Offset 6 holds an 8-bit vector number that is written and read back unchanged.
- R7: With `iack_in` high and `irq` high, `vec_oe` is high, `bus_rdata` equals the vector and `iack_out` is low. With `irq` low, `iack_out` follows `iack_in` and `vec_oe` is low.
- R8: A byte that arrives while bit 0 is set replaces the stored byte and sets the sticky overrun flag, status bit 7. A read of offset 4 clears the flag, unless another overrun happens in the same cycle.
- R9: Accesses that are odd-addressed, or that fall outside the eight-byte window at the base, change no register.
- R10: A byte that arrives in the same cycle as a read of offset 0 leaves bit 0 set and holds the new byte. The read returns the old byte, and no overrun is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus cycle valid |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, or the vector during acknowledge |
| irq | output | 1 | Interrupt request |
| iack_in | input | 1 | Acknowledge from upstream |
| iack_out | output | 1 | Acknowledge passed downstream |
| vec_oe | output | 1 | This port is driving its vector |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Transmit byte pending |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Peripheral takes the transmit byte |

## Verification
Each flag bit is visible in the status word on the first read after the edge that changed it. A wrong bit therefore shows up one cycle after the fault, both in that read and in `irq`. A lost acknowledge or a double acknowledge shows up in the same cycle as a wrong `iack_out` or `vec_oe` level. A corrupted vector or data byte stays hidden until the next read or acknowledge. For that reason the bench reads back every register right after each stimulus.

// File: rtl/vio_port.sv
module vio_port #(
  parameter int          ADDR_W  = 16,
  parameter logic [15:0] BASE    = 16'h8000,
  parameter logic [7:0]  RST_VEC = 8'd15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq,
  input  logic              iack_in,
  output logic              iack_out,
  output logic              vec_oe,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_ready
);
  localparam logic [ADDR_W-1:0] BASE_A = BASE[ADDR_W-1:0];

  logic [7:0] rx_q, tx_q, vec_q;
  logic       sin, sout, ie_in, ie_out, ovr;

  logic       hit;
  logic [1:0] off;
  assign hit = bus_sel && !bus_addr[0] && (bus_addr[ADDR_W-1:3] == BASE_A[ADDR_W-1:3]);
  assign off = bus_addr[2:1];

  logic rd_in, wr_out, rd_st, wr_st, wr_vec;
  assign rd_in  = hit && !bus_we && off == 2'd0;
  assign wr_out = hit &&  bus_we && off == 2'd1;
  assign rd_st  = hit && !bus_we && off == 2'd2;
  assign wr_st  = hit &&  bus_we && off == 2'd2;
  assign wr_vec = hit &&  bus_we && off == 2'd3;

  logic [7:0] status;
  assign status = {ovr, 3'b000, ie_out, ie_in, sout, sin};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_q <= '0; tx_q <= '0; vec_q <= RST_VEC;
      sin <= 1'b0; sout <= 1'b1; ie_in <= 1'b0; ie_out <= 1'b0; ovr <= 1'b0;
    end else begin
      if (rx_valid) begin
        rx_q <= rx_data;
        sin  <= 1'b1;
      end else if (rd_in) begin
        sin  <= 1'b0;
      end

      if (rx_valid && sin && !rd_in) ovr <= 1'b1;
      else if (rd_st)                ovr <= 1'b0;

      if (wr_out) begin
        tx_q <= bus_wdata;
        sout <= 1'b0;
      end else if (!sout && tx_ready) begin
        sout <= 1'b1;
      end

      if (wr_st) begin
        ie_in  <= bus_wdata[2];
        ie_out <= bus_wdata[3];
      end

      if (wr_vec) vec_q <= bus_wdata;
    end
  end

  assign irq      = (sin && ie_in) || (sout && ie_out);
  assign vec_oe   = iack_in && irq;
  assign iack_out = iack_in && !irq;
  assign tx_valid = !sout;
  assign tx_data  = tx_q;

  always_comb begin
    bus_rdata = 8'h00;
    if (vec_oe) bus_rdata = vec_q;
    else if (hit && !bus_we) begin
      case (off)
        2'd0:    bus_rdata = rx_q;
        2'd1:    bus_rdata = tx_q;
        2'd2:    bus_rdata = status;
        default: bus_rdata = vec_q;
      endcase
    end
  end

  a_r2_rx_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> sin);
  a_r2_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_in && !rx_valid) |=> !sin);
  a_r3_write_raises_valid: assert property (@(posedge clk) disable iff (!rst_n)
    wr_out |=> tx_valid);
  a_r3_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !wr_out) |=> (tx_valid && $stable(tx_data)));
  a_r6_vec_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_vec |=> $stable(vec_q));
  a_r8_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && sin && !rd_in) |=> status[7]);
endmodule

// File: tb/vio_port_tb.sv
module vio_port_tb;
  localparam logic [15:0] BASE = 16'h8000;
  localparam logic [2:0] O_IN = 3'd0, O_OUT = 3'd2, O_ST = 3'd4, O_VEC = 3'd6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 0, bus_we = 0, iack_in = 0, rx_valid = 0, tx_ready = 0;
  logic [15:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, rx_data = '0;
  logic [7:0] bus_rdata, tx_data;
  logic irq, iack_out, vec_oe, tx_valid;

  always #2 clk = ~clk;

  vio_port #(.ADDR_W(16), .BASE(BASE), .RST_VEC(8'd15)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .iack_in(iack_in), .iack_out(iack_out), .vec_oe(vec_oe),
    .rx_valid(rx_valid), .rx_data(rx_data), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready));

  int applied = 0, bad = 0;
  bit mon_en = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always @(negedge clk) begin
    if (mon_en && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      applied++;
      if (bus_rdata !== e) begin
        bad++;
        $display("FAIL %s: read got %02h expected %02h", t, bus_rdata, e);
      end
    end
  end

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string t);
    applied++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %02h expected %02h", t, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    bus_sel = 0; bus_we = 0; rx_valid = 0; tx_ready = 0; mon_en = 0;
  endtask

  task automatic wr_raw(input logic [15:0] a, input logic [7:0] d);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    step();
  endtask

  task automatic wr(input logic [2:0] o, input logic [7:0] d);
    wr_raw(BASE + 16'(o), d);
  endtask

  task automatic rd(input logic [2:0] o, input logic [7:0] e, input string t);
    bus_sel = 1; bus_we = 0; bus_addr = BASE + 16'(o);
    exp_q.push_back(e); tag_q.push_back(t); mon_en = 1;
    step();
  endtask

  task automatic rx(input logic [7:0] d);
    rx_valid = 1; rx_data = d;
    step();
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 50000);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1
    rd(O_ST, 8'h02, "R1 status");
    rd(O_VEC, 8'd15, "R1 vector");
    chk({7'b0, irq}, 8'h00, "R1 irq");
    chk({7'b0, tx_valid}, 8'h00, "R1 tx_valid");
    // R6
    wr(O_VEC, 8'd64);
    rd(O_VEC, 8'd64, "R6 vector");
    // R2
    rx(8'hA5);
    rd(O_ST, 8'h03, "R2 sin set");
    rd(O_IN, 8'hA5, "R2 data");
    rd(O_ST, 8'h02, "R2 sin cleared");
    // R8
    rx(8'h11);
    rx(8'h22);
    rd(O_ST, 8'h83, "R8 overrun set");
    rd(O_ST, 8'h03, "R8 overrun cleared");
    rd(O_IN, 8'h22, "R8 newest byte");
    // R10
    rx(8'h33);
    bus_sel = 1; bus_we = 0; bus_addr = BASE + 16'(O_IN);
    rx_valid = 1; rx_data = 8'h44;
    exp_q.push_back(8'h33); tag_q.push_back("R10 old byte"); mon_en = 1;
    step();
    rd(O_ST, 8'h03, "R10 sin kept no overrun");
    rd(O_IN, 8'h44, "R10 new byte");
    // R3
    wr(O_OUT, 8'h5A);
    chk({7'b0, tx_valid}, 8'h01, "R3 tx_valid");
    chk(tx_data, 8'h5A, "R3 tx_data");
    rd(O_ST, 8'h00, "R3 sout clear");
    chk(tx_data, 8'h5A, "R3 tx_data held");
    tx_ready = 1;
    step();
    chk({7'b0, tx_valid}, 8'h00, "R3 tx_valid dropped");
    rd(O_ST, 8'h02, "R3 sout set");
    // R4
    wr(O_ST, 8'hF3);
    rd(O_ST, 8'h02, "R4 other bits ignored");
    wr(O_ST, 8'hFF);
    rd(O_ST, 8'h0E, "R4 enables read back");
    // R5
    chk({7'b0, irq}, 8'h01, "R5 irq from tx enable");
    // R7
    iack_in = 1; #1;
    chk({7'b0, vec_oe}, 8'h01, "R7 vec_oe");
    chk(bus_rdata, 8'd64, "R7 vector on bus");
    chk({7'b0, iack_out}, 8'h00, "R7 ack not passed");
    iack_in = 0;
    wr(O_ST, 8'h04);
    chk({7'b0, irq}, 8'h00, "R5 irq low rx enable only");
    rx(8'h77);
    chk({7'b0, irq}, 8'h01, "R5 irq from rx");
    rd(O_IN, 8'h77, "R5 service read");
    chk({7'b0, irq}, 8'h00, "R5 irq cleared after service");
    iack_in = 1; #1;
    chk({7'b0, iack_out}, 8'h01, "R7 ack passed");
    chk({7'b0, vec_oe}, 8'h00, "R7 no vector");
    iack_in = 0;
    // R9
    wr_raw(16'h8008, 8'h99);
    wr_raw(16'h9006, 8'h99);
    wr_raw(16'h8007, 8'h99);
    rd(O_VEC, 8'd64, "R9 vector untouched");
    rd(O_ST, 8'h06, "R9 status untouched");
    step();
    finish_up();
  end
endmodule